// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Controller

This block sits between the current-sense comparators and the gate-drive logic of a synchronous buck controller. Once per switching cycle it takes a valley-limit result, sampled when the low-side on-time ends, and decides what the next cycle may do. If the valley limit was seen, it skips the next high-side pulse. A sink-limit event during the low-side on-time makes it switch the low-side driver off for the rest of that cycle. When valley-limit events keep outweighing clean cycles, it shuts both drivers down for a fixed number of switching cycles, holds power-good low, and then asks the soft-start sequencer to ramp up again.

Persistence is tracked by a small saturating up/down event counter, not by a run of back-to-back events. Each cycle with a valley event adds one. Each clean cycle takes one away, and the counter never goes below zero. Reaching the counter's top value starts the shutdown. The counter keeps working while a soft-start ramp is in progress, because it sees only the cycle strobe and the limit flags.

The controller has two states. In ST_RUN the per-cycle actions are live and the event counter is updated. Transition TRIP (ST_RUN to ST_HICCUP) happens on the strobe whose valley event brings the counter to its top value. In ST_HICCUP every limit input is ignored and a wait timer counts strobes. Transition TIMEOUT (ST_HICCUP to ST_RUN) happens on the last strobe of the wait.

Top module: `hiccup_ocp_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after reset, all five outputs are low and the event counter is zero.
- R2: A strobe with `valley_hit` high adds one to the event counter. A strobe with `valley_hit` low subtracts one, and the counter stays at zero if it is already there. With default parameters the counter is 3 bits and its top value is 7.
- R3: On the clock edge of the strobe that brings the counter to 7, `hiccup_on` goes high, and it stays high for the whole wait.
- R4: The wait lasts `WAIT_CYCLES` strobes (default 4096), counted after the trip strobe. On the edge of the last of these strobes, `hiccup_on` falls and `ss_restart` is high for exactly one clock.
- R5: `pg_force_low` is high during exactly the clocks in which `hiccup_on` is high.
- R6: The event counter is cleared on the TRIP transition. After a restart, six valley events in a row do not trip, and a seventh does.
- R7: In ST_RUN, after each strobe `skip_pulse` takes the value `valley_hit` had at that strobe and holds it until the next strobe.
- R8: In ST_RUN, `ls_force_off` goes high on the clock after `sink_hit` is high while `ls_window` is high. It stays high until the next strobe clears it. A `sink_hit` while `ls_window` is low has no effect.
- R9: While `hiccup_on` is high, `skip_pulse` and `ls_force_off` stay low, and `valley_hit` and `sink_hit` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-clock pulse at the end of each switching cycle's low-side on-time |
| valley_hit | input | 1 | Valley current limit exceeded, valid with `cyc_stb` |
| sink_hit | input | 1 | Sink current limit exceeded, may occur at any clock |
| ls_window | input | 1 | High while the low-side switch is commanded on |
| skip_pulse | output | 1 | Suppress the next high-side pulse |
| ls_force_off | output | 1 | Turn the low-side driver off for the rest of this cycle |
| hiccup_on | output | 1 | Both drivers disabled for the hiccup wait |
| pg_force_low | output | 1 | Hold power-good low |
| ss_restart | output | 1 | One-clock request to start a new soft-start ramp |

## Verification
On every cycle, the assertions check how the event counter steps, that it clears at TRIP, and that the timer holds between strobes. They also check that each rise of `skip_pulse`, `ls_force_off` and `hiccup_on` has the right input cause, that the per-cycle actions stay low during the hiccup, and that `ss_restart` is a single pulse timed to the fall of `hiccup_on`. Only the bench's scenarios can show whole patterns. These include the exact strobe count of the wait, the count of seven net events needed to trip after a mix of hits and clean cycles, the counter holding at zero, the clean counter after a restart, and limit inputs being ignored during the hiccup.

// File: rtl/hiccup_ocp_pkg.sv
package hiccup_ocp_pkg;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_HICCUP = 1'b1
    } hocp_state_e;

endpackage

// File: rtl/ocp_event_counter.sv
module ocp_event_counter #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic hit,
    output logic trip
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            if (hit) begin
                if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // the event that would take the count to its top value
    assign trip = step && hit && (cnt == CNT_TOP - 1'b1);

    assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit && !clr && cnt == '0) |=> (cnt == '0));

    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hit && !clr && cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1));

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit && !clr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_clear_on_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/ocp_wait_timer.sv
module ocp_wait_timer #(
    parameter int WAIT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic step,
    output logic done
);
    localparam int TW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WAIT_CYCLES - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign done = run && step && (cnt == LAST);

    assert_hold_between_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt));

    assert_advance_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/ocp_cycle_actions.sv
module ocp_cycle_actions (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_stb,
    input  logic valley_hit,
    input  logic sink_hit,
    input  logic ls_window,
    output logic skip_pulse,
    output logic ls_force_off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_pulse <= 1'b0;
        end else if (!en) begin
            skip_pulse <= 1'b0;
        end else if (cyc_stb) begin
            skip_pulse <= valley_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_force_off <= 1'b0;
        end else if (!en || cyc_stb) begin
            ls_force_off <= 1'b0;
        end else if (ls_window && sink_hit) begin
            ls_force_off <= 1'b1;
        end
    end

    assert_skip_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_pulse) |-> $past(cyc_stb && valley_hit));

    assert_force_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_force_off) |-> $past(sink_hit && ls_window));

    assert_force_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_force_off) |-> $past(cyc_stb || !en));

endmodule

// File: rtl/hiccup_ocp_ctrl.sv
module hiccup_ocp_ctrl
    import hiccup_ocp_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int WAIT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic valley_hit,
    input  logic sink_hit,
    input  logic ls_window,
    output logic skip_pulse,
    output logic ls_force_off,
    output logic hiccup_on,
    output logic pg_force_low,
    output logic ss_restart
);
    hocp_state_e state, state_nxt;
    logic        trip, wait_done, in_run, act_en;

    assign in_run = (state == ST_RUN);
    assign act_en = in_run && !trip;

    ocp_event_counter #(.CNT_W(CNT_W)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trip),
        .step  (cyc_stb && in_run),
        .hit   (valley_hit),
        .trip  (trip)
    );

    ocp_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_HICCUP),
        .step  (cyc_stb),
        .done  (wait_done)
    );

    ocp_cycle_actions u_actions (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (act_en),
        .cyc_stb      (cyc_stb),
        .valley_hit   (valley_hit),
        .sink_hit     (sink_hit),
        .ls_window    (ls_window),
        .skip_pulse   (skip_pulse),
        .ls_force_off (ls_force_off)
    );

    // transitions: TRIP (run -> hiccup), TIMEOUT (hiccup -> run)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:    if (trip)      state_nxt = ST_HICCUP;
            ST_HICCUP: if (wait_done) state_nxt = ST_RUN;
            default:                  state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hiccup_on    <= 1'b0;
            pg_force_low <= 1'b0;
            ss_restart   <= 1'b0;
        end else begin
            hiccup_on    <= (state_nxt == ST_HICCUP);
            pg_force_low <= (state_nxt == ST_HICCUP);
            ss_restart   <= (state == ST_HICCUP) && (state_nxt == ST_RUN);
        end
    end

    assert_hiccup_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hiccup_on) |-> $past(cyc_stb && valley_hit));

    assert_hiccup_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hiccup_on) |-> ss_restart);

    assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |=> !ss_restart);

    assert_pg_with_hiccup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_force_low) |-> $rose(hiccup_on));

    assert_quiet_in_hiccup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup_on |-> (!skip_pulse && !ls_force_off));

endmodule

// File: tb/hiccup_ocp_ctrl_bench.sv
module hiccup_ocp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_N     = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, valley_hit = 1'b0, sink_hit = 1'b0, ls_window = 1'b0;
    logic skip_pulse, ls_force_off, hiccup_on, pg_force_low, ss_restart;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiccup_ocp_ctrl #(.CNT_W(3), .WAIT_CYCLES(WAIT_N)) u_hiccup_ocp_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .valley_hit(valley_hit),
        .sink_hit(sink_hit), .ls_window(ls_window), .skip_pulse(skip_pulse),
        .ls_force_off(ls_force_off), .hiccup_on(hiccup_on),
        .pg_force_low(pg_force_low), .ss_restart(ss_restart)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one strobe; returns just after the edge that sampled it
    task automatic stb(input logic v);
        @(negedge clk);
        cyc_stb = 1'b1; valley_hit = v;
        @(negedge clk);
        cyc_stb = 1'b0; valley_hit = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 skip_pulse in reset", skip_pulse, 1'b0);
        check("R1 hiccup_on in reset", hiccup_on, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 skip_pulse", skip_pulse, 1'b0);
        check("R1 ls_force_off", ls_force_off, 1'b0);
        check("R1 hiccup_on", hiccup_on, 1'b0);
        check("R1 pg_force_low", pg_force_low, 1'b0);
        check("R1 ss_restart", ss_restart, 1'b0);
    endtask

    task automatic t_skip;
        stb(1'b1);
        check("R7 skip after valley", skip_pulse, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 skip held", skip_pulse, 1'b1);
        stb(1'b0);
        check("R7 skip cleared", skip_pulse, 1'b0);
    endtask

    task automatic t_sink;
        @(negedge clk); ls_window = 1'b1;
        @(negedge clk); sink_hit = 1'b1;
        @(negedge clk); sink_hit = 1'b0;
        check("R8 force on sink", ls_force_off, 1'b1);
        @(negedge clk); ls_window = 1'b0;
        check("R8 force held", ls_force_off, 1'b1);
        @(negedge clk);
        check("R8 force held after window", ls_force_off, 1'b1);
        stb(1'b0);
        check("R8 force cleared by strobe", ls_force_off, 1'b0);
        sink_hit = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 sink outside window ignored", ls_force_off, 1'b0);
        sink_hit = 1'b0;
    endtask

    task automatic t_alternate;
        for (int i = 0; i < 10; i++) begin
            stb(1'b1);
            stb(1'b0);
        end
        check("R2 alternating never trips", hiccup_on, 1'b0);
    endtask

    task automatic t_zero_hold;
        for (int i = 0; i < 5; i++) stb(1'b0);
        for (int i = 0; i < 6; i++) stb(1'b1);
        check("R2 six events below trip", hiccup_on, 1'b0);
        stb(1'b0);
        stb(1'b1);
        check("R2 net six after decrement", hiccup_on, 1'b0);
        stb(1'b1);
        check("R3 trip at count seven", hiccup_on, 1'b1);
        check("R5 pg low at trip", pg_force_low, 1'b1);
        check("R9 skip low at trip", skip_pulse, 1'b0);
    endtask

    task automatic t_wait;
        for (int i = 1; i < WAIT_N; i++) begin
            if (i == 5) begin
                ls_window = 1'b1; sink_hit = 1'b1;
            end
            stb((i % 2) == 0);
            if (i == 5) begin
                @(negedge clk);
                check("R9 sink ignored in hiccup", ls_force_off, 1'b0);
                ls_window = 1'b0; sink_hit = 1'b0;
            end
            if (i == 6) check("R9 valley ignored in hiccup", skip_pulse, 1'b0);
            if (i == 100) check("R5 pg low mid wait", pg_force_low, 1'b1);
        end
        check("R4 still in hiccup before last strobe", hiccup_on, 1'b1);
        check("R5 pg low before last strobe", pg_force_low, 1'b1);
        check("R4 no restart early", ss_restart, 1'b0);
        stb(1'b0);
        check("R4 hiccup ends", hiccup_on, 1'b0);
        check("R4 restart pulse", ss_restart, 1'b1);
        check("R5 pg released", pg_force_low, 1'b0);
        @(negedge clk);
        check("R4 restart one clock", ss_restart, 1'b0);
    endtask

    task automatic t_clear_after_restart;
        for (int i = 0; i < 6; i++) stb(1'b1);
        check("R6 six events after restart", hiccup_on, 1'b0);
        stb(1'b1);
        check("R6 seventh trips", hiccup_on, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_skip();
        t_sink();
        t_alternate();
        t_zero_hold();
        t_wait();
        t_clear_after_restart();
        t_wait();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule